// File: doc/BRIEF.md
# Steady-State Genetic Search Engine

This block runs a steady-state genetic search over fixed-length bit-string chromosomes. It keeps a population store in which every entry holds a chromosome and its cost. After a start pulse it fills the store with random chromosomes, each one scored through an external cost port. It then repeats one breeding step until a programmed number of children has been scored.

In each breeding step, the first parent held from the previous step becomes the second parent, and a new first parent is drawn from a random address. The more costly of the two parents is marked for replacement. A child is assembled bit by bit from a crossover run pattern, with random bit flips applied, and is sent out for scoring. The child overwrites the marked parent only when its cost is strictly lower. All randomness comes from one internal 32-bit xorshift generator, so a given seed always gives the same search.

Every store write is shown on a write-event port. The engine also reports run status, the number of children scored, the number of survivors and the lowest cost written so far. An optional epoch mode flips a target-inversion flag at a fixed child interval. The external cost function uses this flag to change the problem it scores against.

Top module: `ga_engine`

## Requirements
- R1: The generator holds 32 bits. A draw sets x = x ^ (x << 13), then x = x ^ (x >> 17), then x = x ^ (x << 5), and returns the new x. A start loads seed_i into it, and a zero seed loads 1 instead. The state changes only on draws.
- R2: After start, entries 0 to POP_DEPTH-1 are filled in ascending order. Each chromosome is bits [CHROM_W-1:0] of one draw. Each is scored through the cost port and then shown as one write event.
- R3: A parent address is bits [AW-1:0] of one draw, where AW = ceil(log2(POP_DEPTH)). A value of POP_DEPTH or more is dropped and the engine draws again. No write address is ever POP_DEPTH or more.
- R4: Each step copies the held first parent (chromosome, cost, address) into the second parent, then reads the new first parent from the drawn address. After the fill, the held first parent is the entry written last (address POP_DEPTH-1). If a survivor replaces the held first parent's entry, that copy is refreshed with the child.
- R5: The first parent is the replacement candidate when its cost is strictly greater than the second parent's. Otherwise, including on a tie, the second parent is the candidate.
- R6: After the address draw, the child takes one draw per bit, from bit 0 up to bit CHROM_W-1. A run flag starts at 1 for each child and is inverted before use when draw[15:0] < cut_thr_i. The bit comes from the first parent while the flag is 1 and from the second parent while it is 0. The bit is then inverted when draw[31:16] < mut_thr_i.
- R7: cost_req_o stays high with a stable cost_chrom_o until cost_ack_i is seen. cost_val_i is taken in that same cycle.
- R8: A scored child is written to the candidate address only when its cost is strictly below the candidate's cost. After the fill, no write raises the cost stored at an entry.
- R9: xover_cnt_o counts scored children and surv_cnt_o counts survivors. The run ends in the cycle after child number xover_lim_i is scored (xover_lim_i must be at least 1). busy_o then falls and done_o stays high until the next start.
- R10: best_cost_o equals all ones after reset and after a start. It then follows the minimum of every cost written since that start.
- R11: When epoch_len_i is not zero, cost_inv_o inverts each time the child count reaches a multiple of epoch_len_i. A start clears it. A value of zero disables it.
- R12: A start pulse while busy_o is high has no effect.
- R13: After reset, busy_o, done_o, cost_req_o and wr_valid_o are low, both counters are zero and best_cost_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle |
| seed_i | input | 32 | Generator seed loaded at start |
| cut_thr_i | input | 16 | Crossover run-switch threshold |
| mut_thr_i | input | 16 | Bit-flip threshold |
| xover_lim_i | input | CNT_W | Number of children per run |
| epoch_len_i | input | CNT_W | Children between target inversions, 0 = off |
| cost_req_o | output | 1 | Cost request |
| cost_chrom_o | output | CHROM_W | Chromosome to be scored |
| cost_inv_o | output | 1 | Target-inversion flag for the cost function |
| cost_ack_i | input | 1 | Cost response valid |
| cost_val_i | input | COST_W | Cost of the requested chromosome |
| wr_valid_o | output | 1 | Store write this cycle |
| wr_addr_o | output | ceil(log2(POP_DEPTH)) | Write address |
| wr_chrom_o | output | CHROM_W | Chromosome written |
| wr_cost_o | output | COST_W | Cost written |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished |
| best_cost_o | output | COST_W | Lowest cost written in this run |
| xover_cnt_o | output | CNT_W | Children scored |
| surv_cnt_o | output | CNT_W | Survivors written |

## Verification
The bench builds the engine with 20-bit chromosomes, 12 store entries, 16-bit costs and 20-bit counters. Because 12 is not a power of two, the rejecting address reducer is the variant that gets built. About a quarter of address draws are then dropped, which tests the redraw path and the draw ordering that follows it. The cost function in the bench has a narrow range, so equal parent costs occur often and the tie rule decides real replacements. Four runs cover seed zero, a cut threshold of zero, a threshold of all ones, an epoch interval and a start pulse sent mid-run.

// File: rtl/ga_pkg.sv
`timescale 1ns/1ps
package ga_pkg;
   localparam int RND_W  = 32;
   localparam int PROB_W = 16;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FILL_DRAW,
      S_FILL_EVAL,
      S_PICK,
      S_BREED,
      S_JUDGE
   } eng_state_t;

   // one xorshift step
   function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] s);
      logic [RND_W-1:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction
endpackage

// File: rtl/ga_rng.sv
`timescale 1ns/1ps
module ga_rng
   import ga_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [RND_W-1:0] seed_i,
   input  logic             adv_i,
   output logic [RND_W-1:0] draw_o
);
   logic [RND_W-1:0] state_q;

   assign draw_o = rnd_next(state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= RND_W'(1);
      else if (load_i) state_q <= (seed_i == '0) ? RND_W'(1) : seed_i;
      else if (adv_i)  state_q <= draw_o;
   end

   AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R1
endmodule

// File: rtl/ga_tmpl.sv
`timescale 1ns/1ps
module ga_tmpl
   import ga_pkg::*;
#(
   parameter int WIDTH = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   input  logic [RND_W-1:0]  rnd_i,
   input  logic [PROB_W-1:0] cut_thr_i,
   input  logic [PROB_W-1:0] mut_thr_i,
   input  logic [WIDTH-1:0]  pa_i,
   input  logic [WIDTH-1:0]  pb_i,
   output logic [WIDTH-1:0]  child_o,
   output logic              last_o
);
   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(WIDTH - 1);

   logic [IW-1:0]    idx_q;
   logic             run_q;
   logic [WIDTH-1:0] child_q;
   logic             run_nx;
   logic             bit_nx;

   always_comb begin
      run_nx = run_q ^ (rnd_i[PROB_W-1:0] < cut_thr_i);
      bit_nx = (run_nx ? pa_i[idx_q] : pb_i[idx_q])
             ^ (rnd_i[2*PROB_W-1:PROB_W] < mut_thr_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         run_q   <= 1'b1;
         child_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
         run_q <= 1'b1;
      end else if (adv_i) begin
         child_q[idx_q] <= bit_nx;
         run_q          <= run_nx;
         idx_q          <= idx_q + 1'b1;
      end
   end

   assign child_o = child_q;
   assign last_o  = (idx_q == LAST_IDX);

   AST_TMPL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> idx_q <= LAST_IDX); // R6
endmodule

// File: rtl/ga_pop_mem.sv
`timescale 1ns/1ps
module ga_pop_mem #(
   parameter int DW    = 20,
   parameter int CW    = 16,
   parameter int DEPTH = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic                     fill_i,
   input  logic [$clog2(DEPTH)-1:0] waddr_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic [CW-1:0]            wcost_i,
   input  logic [$clog2(DEPTH)-1:0] raddr_i,
   output logic [DW-1:0]            rdata_o,
   output logic [CW-1:0]            rcost_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

   logic [DW-1:0] data_w [DEPTH];
   logic [CW-1:0] cost_w [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DW-1:0] d_q;
      logic [CW-1:0] c_q;
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == AW'(e))) begin
            d_q <= wdata_i;
            c_q <= wcost_i;
         end
      end
      assign data_w[e] = d_q;
      assign cost_w[e] = c_q;
   end

   assign rdata_o = data_w[raddr_i];
   assign rcost_o = cost_w[raddr_i];

   AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> {1'b0, waddr_i} < DEPTH_C); // R3
   AST_COST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !fill_i) |-> wcost_i < cost_w[waddr_i]); // R8
endmodule

// File: rtl/ga_engine.sv
`timescale 1ns/1ps
module ga_engine
   import ga_pkg::*;
#(
   parameter int CHROM_W   = 20,
   parameter int POP_DEPTH = 12,
   parameter int COST_W    = 16,
   parameter int CNT_W     = 20
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [31:0]                  seed_i,
   input  logic [15:0]                  cut_thr_i,
   input  logic [15:0]                  mut_thr_i,
   input  logic [CNT_W-1:0]             xover_lim_i,
   input  logic [CNT_W-1:0]             epoch_len_i,
   output logic                         cost_req_o,
   output logic [CHROM_W-1:0]           cost_chrom_o,
   output logic                         cost_inv_o,
   input  logic                         cost_ack_i,
   input  logic [COST_W-1:0]            cost_val_i,
   output logic                         wr_valid_o,
   output logic [$clog2(POP_DEPTH)-1:0] wr_addr_o,
   output logic [CHROM_W-1:0]           wr_chrom_o,
   output logic [COST_W-1:0]            wr_cost_o,
   output logic                         busy_o,
   output logic                         done_o,
   output logic [COST_W-1:0]            best_cost_o,
   output logic [CNT_W-1:0]             xover_cnt_o,
   output logic [CNT_W-1:0]             surv_cnt_o
);
   localparam int AW = $clog2(POP_DEPTH);
   localparam logic [AW:0]   DEPTH_C = (AW + 1)'(POP_DEPTH);
   localparam logic [AW-1:0] LAST_A  = AW'(POP_DEPTH - 1);

   // elaboration-time parameter checks
   if (CHROM_W < 2 || CHROM_W > RND_W) begin : g_bad_chrom
      $error("ga_engine: CHROM_W must lie in 2..32");
   end
   if (POP_DEPTH < 2) begin : g_bad_depth
      $error("ga_engine: POP_DEPTH must be at least 2");
   end
   if (COST_W < 1 || CNT_W < 2) begin : g_bad_cnt
      $error("ga_engine: COST_W and CNT_W too small");
   end

   eng_state_t state_q;
   logic [AW-1:0]      fill_idx_q;
   logic [CHROM_W-1:0] fill_chrom_q;
   logic [CHROM_W-1:0] p1_chrom_q, p2_chrom_q;
   logic [COST_W-1:0]  p1_cost_q, p2_cost_q;
   logic [AW-1:0]      p1_addr_q, p2_addr_q;
   logic [COST_W-1:0]  worst_cost_q;
   logic [AW-1:0]      worst_addr_q;
   logic [CNT_W-1:0]   xcnt_q, scnt_q, ecnt_q;
   logic               inv_q, done_q;
   logic [COST_W-1:0]  best_q;

   logic [RND_W-1:0]   rnd;
   logic               rng_load, rng_adv;
   logic [AW-1:0]      cand_addr;
   logic               addr_ok;
   logic [CHROM_W-1:0] rd_chrom, child;
   logic [COST_W-1:0]  rd_cost;
   logic               tmpl_last;
   logic               ack_ok, surv, mem_we, fill_we;
   logic [AW-1:0]      mem_waddr;
   logic [CHROM_W-1:0] mem_wdata;
   logic [CNT_W-1:0]   xcnt_nx, ecnt_nx;

   // address reduction variant chosen by depth
   assign cand_addr = rnd[AW-1:0];
   if ((1 << AW) == POP_DEPTH) begin : g_addr_pow2
      assign addr_ok = 1'b1;
   end else begin : g_addr_reject
      assign addr_ok = ({1'b0, cand_addr} < DEPTH_C);
   end

   assign rng_load = (state_q == S_IDLE) && start_i;
   assign rng_adv  = (state_q == S_FILL_DRAW) || (state_q == S_PICK) || (state_q == S_BREED);

   ga_rng u_rng (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (rng_load),
      .seed_i (seed_i),
      .adv_i  (rng_adv),
      .draw_o (rnd)
   );

   ga_tmpl #(.WIDTH(CHROM_W)) u_tmpl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (state_q == S_PICK),
      .adv_i     (state_q == S_BREED),
      .rnd_i     (rnd),
      .cut_thr_i (cut_thr_i),
      .mut_thr_i (mut_thr_i),
      .pa_i      (p1_chrom_q),
      .pb_i      (p2_chrom_q),
      .child_o   (child),
      .last_o    (tmpl_last)
   );

   always_comb begin
      cost_req_o   = (state_q == S_FILL_EVAL) || (state_q == S_JUDGE);
      cost_chrom_o = (state_q == S_FILL_EVAL) ? fill_chrom_q : child;
      ack_ok       = cost_req_o && cost_ack_i;
      fill_we      = (state_q == S_FILL_EVAL) && ack_ok;
      surv         = (state_q == S_JUDGE) && ack_ok && (cost_val_i < worst_cost_q);
      mem_we       = fill_we || surv;
      mem_waddr    = fill_we ? fill_idx_q : worst_addr_q;
      mem_wdata    = fill_we ? fill_chrom_q : child;
      xcnt_nx      = xcnt_q + 1'b1;
      ecnt_nx      = ecnt_q + 1'b1;
   end

   ga_pop_mem #(.DW(CHROM_W), .CW(COST_W), .DEPTH(POP_DEPTH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .fill_i  (fill_we),
      .waddr_i (mem_waddr),
      .wdata_i (mem_wdata),
      .wcost_i (cost_val_i),
      .raddr_i (cand_addr),
      .rdata_o (rd_chrom),
      .rcost_o (rd_cost)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         fill_idx_q   <= '0;
         fill_chrom_q <= '0;
         p1_chrom_q   <= '0;
         p1_cost_q    <= '0;
         p1_addr_q    <= '0;
         p2_chrom_q   <= '0;
         p2_cost_q    <= '0;
         p2_addr_q    <= '0;
         worst_cost_q <= '0;
         worst_addr_q <= '0;
         xcnt_q       <= '0;
         scnt_q       <= '0;
         ecnt_q       <= '0;
         inv_q        <= 1'b0;
         done_q       <= 1'b0;
         best_q       <= '1;
      end else begin
         unique case (state_q)
            S_IDLE: if (start_i) begin
               done_q     <= 1'b0;
               xcnt_q     <= '0;
               scnt_q     <= '0;
               ecnt_q     <= '0;
               inv_q      <= 1'b0;
               best_q     <= '1;
               fill_idx_q <= '0;
               state_q    <= S_FILL_DRAW;
            end
            S_FILL_DRAW: begin
               fill_chrom_q <= rnd[CHROM_W-1:0];
               state_q      <= S_FILL_EVAL;
            end
            S_FILL_EVAL: if (ack_ok) begin
               p1_chrom_q <= fill_chrom_q;
               p1_cost_q  <= cost_val_i;
               p1_addr_q  <= fill_idx_q;
               if (cost_val_i < best_q) best_q <= cost_val_i;
               if (fill_idx_q == LAST_A) begin
                  state_q <= S_PICK;
               end else begin
                  fill_idx_q <= fill_idx_q + 1'b1;
                  state_q    <= S_FILL_DRAW;
               end
            end
            S_PICK: if (addr_ok) begin
               p2_chrom_q <= p1_chrom_q;
               p2_cost_q  <= p1_cost_q;
               p2_addr_q  <= p1_addr_q;
               p1_chrom_q <= rd_chrom;
               p1_cost_q  <= rd_cost;
               p1_addr_q  <= cand_addr;
               if (rd_cost > p1_cost_q) begin
                  worst_cost_q <= rd_cost;
                  worst_addr_q <= cand_addr;
               end else begin
                  worst_cost_q <= p1_cost_q;
                  worst_addr_q <= p1_addr_q;
               end
               state_q <= S_BREED;
            end
            S_BREED: if (tmpl_last) state_q <= S_JUDGE;
            S_JUDGE: if (ack_ok) begin
               xcnt_q <= xcnt_nx;
               if (surv) begin
                  scnt_q <= scnt_q + 1'b1;
                  if (cost_val_i < best_q) best_q <= cost_val_i;
                  if (worst_addr_q == p1_addr_q) begin
                     p1_chrom_q <= child;
                     p1_cost_q  <= cost_val_i;
                  end
               end
               if (epoch_len_i != '0) begin
                  if (ecnt_nx == epoch_len_i) begin
                     inv_q  <= ~inv_q;
                     ecnt_q <= '0;
                  end else begin
                     ecnt_q <= ecnt_nx;
                  end
               end
               if (xcnt_nx == xover_lim_i) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  state_q <= S_PICK;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cost_inv_o  = inv_q;
   assign wr_valid_o  = mem_we;
   assign wr_addr_o   = mem_waddr;
   assign wr_chrom_o  = mem_wdata;
   assign wr_cost_o   = cost_val_i;
   assign busy_o      = (state_q != S_IDLE);
   assign done_o      = done_q;
   assign best_cost_o = best_q;
   assign xover_cnt_o = xcnt_q;
   assign surv_cnt_o  = scnt_q;

   wire unused_p2 = ^{p2_cost_q, p2_addr_q};

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cost_req_o && !cost_ack_i) |=> (cost_req_o && $stable(cost_chrom_o))); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R9
   AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> best_cost_o <= $past(best_cost_o)); // R10
   AST_INV_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(state_q == S_JUDGE && ack_ok)) |=> $stable(cost_inv_o)); // R11
endmodule

// File: tb/tb_ga_engine.sv
`timescale 1ns/1ps
module tb_ga_engine;
   localparam int CW = 20;
   localparam int NP = 12;
   localparam int KW = 16;
   localparam int NW = 20;
   localparam int AW = $clog2(NP);
   localparam logic [CW-1:0] TGT = 20'hA5C3E;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [KW-1:0] c;
      logic [CW-1:0] ch;
   } wr_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, start_i, cost_ack_i;
   logic [31:0]   seed_i;
   logic [15:0]   cut_thr_i, mut_thr_i;
   logic [NW-1:0] xover_lim_i, epoch_len_i;
   logic [KW-1:0] cost_val_i;
   logic          cost_req_o, cost_inv_o, wr_valid_o, busy_o, done_o;
   logic [CW-1:0] cost_chrom_o, wr_chrom_o;
   logic [AW-1:0] wr_addr_o;
   logic [KW-1:0] wr_cost_o, best_cost_o;
   logic [NW-1:0] xover_cnt_o, surv_cnt_o;

   ga_engine #(.CHROM_W(CW), .POP_DEPTH(NP), .COST_W(KW), .CNT_W(NW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
      .cut_thr_i(cut_thr_i), .mut_thr_i(mut_thr_i),
      .xover_lim_i(xover_lim_i), .epoch_len_i(epoch_len_i),
      .cost_req_o(cost_req_o), .cost_chrom_o(cost_chrom_o), .cost_inv_o(cost_inv_o),
      .cost_ack_i(cost_ack_i), .cost_val_i(cost_val_i),
      .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_chrom_o(wr_chrom_o),
      .wr_cost_o(wr_cost_o), .busy_o(busy_o), .done_o(done_o),
      .best_cost_o(best_cost_o), .xover_cnt_o(xover_cnt_o), .surv_cnt_o(surv_cnt_o)
   );

   int nchk = 0;
   int nfail = 0;
   wr_t exp_q[$];
   int exp_x, exp_s;
   logic [KW-1:0] exp_best;
   logic exp_inv;
   logic [KW-1:0] t_c [NP];
   int wcount = 0;

   task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] xs(input logic [31:0] s);
      logic [31:0] v;
      v = s ^ (s << 13);
      v = v ^ (v >> 17);
      return v ^ (v << 5);
   endfunction

   function automatic logic [KW-1:0] costf(input logic [CW-1:0] ch, input logic inv);
      return KW'(2 * $countones(ch ^ (TGT ^ {CW{inv}}))) + KW'(ch[CW-1]);
   endfunction

   // reference model of the search, pushes expected store writes
   task automatic build_model(input logic [31:0] seed, input logic [15:0] cut,
                              input logic [15:0] mut, input int lim, input int ep);
      logic [31:0]   s;
      logic [CW-1:0] m_ch [NP];
      logic [KW-1:0] m_c [NP];
      logic [CW-1:0] c1, c2, kid;
      logic [KW-1:0] k1, k2, wc, kc;
      logic [AW-1:0] a1, a2, wa, na;
      logic run, b, inv;
      int ecnt;
      wr_t w;
      exp_q.delete();
      s = (seed == 0) ? 32'd1 : seed;
      exp_best = '1; exp_s = 0; inv = 1'b0; ecnt = 0;
      for (int i = 0; i < NP; i++) begin
         s = xs(s);
         m_ch[i] = s[CW-1:0];
         m_c[i] = costf(m_ch[i], 1'b0);
         w.a = AW'(i); w.c = m_c[i]; w.ch = m_ch[i];
         exp_q.push_back(w);
         if (m_c[i] < exp_best) exp_best = m_c[i];
      end
      c1 = m_ch[NP-1]; k1 = m_c[NP-1]; a1 = AW'(NP-1);
      for (int n = 0; n < lim; n++) begin
         do begin s = xs(s); na = s[AW-1:0]; end while (int'(na) >= NP);
         c2 = c1; k2 = k1; a2 = a1;
         c1 = m_ch[na]; k1 = m_c[na]; a1 = na;
         if (k1 > k2) begin wc = k1; wa = a1; end else begin wc = k2; wa = a2; end
         run = 1'b1;
         for (int j = 0; j < CW; j++) begin
            s = xs(s);
            if (s[15:0] < cut) run = ~run;
            b = run ? c1[j] : c2[j];
            if (s[31:16] < mut) b = ~b;
            kid[j] = b;
         end
         kc = costf(kid, inv);
         if (kc < wc) begin
            m_ch[wa] = kid; m_c[wa] = kc;
            w.a = wa; w.c = kc; w.ch = kid;
            exp_q.push_back(w);
            exp_s++;
            if (kc < exp_best) exp_best = kc;
            if (wa == a1) begin c1 = kid; k1 = kc; end
         end
         if (ep != 0) begin
            ecnt++;
            if (ecnt == ep) begin inv = ~inv; ecnt = 0; end
         end
      end
      exp_x = lim;
      exp_inv = inv;
   endtask

   // cost responder with a rotating delay of 0..2 cycles
   initial begin
      int wait_n, rot;
      cost_ack_i = 1'b0; cost_val_i = '0; wait_n = 0; rot = 0;
      forever begin
         @(posedge clk); #1;
         if (cost_ack_i) cost_ack_i = 1'b0;
         else if (cost_req_o) begin
            if (wait_n == 0) begin
               cost_ack_i = 1'b1;
               cost_val_i = costf(cost_chrom_o, cost_inv_o);
               rot++;
               wait_n = rot % 3;
            end else wait_n--;
         end
      end
   end

   // monitor: compare each store write with the scoreboard
   initial begin
      wr_t e;
      forever begin
         @(negedge clk);
         if (rst_n && wr_valid_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected write, addr", longint'(wr_addr_o), -1);
            end else begin
               e = exp_q.pop_front();
               chk(wr_addr_o == e.a, "R3/R5 write address", longint'(wr_addr_o), longint'(e.a));
               chk(wr_cost_o == e.c, "R8 write cost", longint'(wr_cost_o), longint'(e.c));
               chk(wr_chrom_o == e.ch, "R2/R6 write chromosome", longint'(wr_chrom_o), longint'(e.ch));
            end
            if (wcount >= NP)
               chk(wr_cost_o < t_c[wr_addr_o], "R8 entry cost drops", longint'(wr_cost_o),
                   longint'(t_c[wr_addr_o]));
            t_c[wr_addr_o] = wr_cost_o;
            wcount++;
         end
      end
   end

   task automatic run_case(input logic [31:0] seed, input logic [15:0] cut, input logic [15:0] mut,
                           input int lim, input int ep, input bit poke);
      bit seen;
      build_model(seed, cut, mut, lim, ep);
      @(posedge clk); #1;
      seed_i = seed; cut_thr_i = cut; mut_thr_i = mut;
      xover_lim_i = NW'(lim); epoch_len_i = NW'(ep);
      wcount = 0;
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
      chk(best_cost_o == '1, "R10 best cleared at start", longint'(best_cost_o), longint'(16'hFFFF));
      if (poke) begin
         repeat (80) @(posedge clk);
         #1 start_i = 1'b1;     // R12: ignored while busy
         @(posedge clk); #1 start_i = 1'b0;
      end
      seen = 1'b0;
      for (int c = 0; c < 40000; c++) begin
         @(negedge clk);
         if (done_o) begin seen = 1'b1; break; end
      end
      chk(seen, "R9 watchdog: run finished", longint'(seen), 1);
      chk(exp_q.size() == 0, "R8 all expected writes seen", longint'(exp_q.size()), 0);
      chk(xover_cnt_o == NW'(exp_x), "R9 child count", longint'(xover_cnt_o), longint'(exp_x));
      chk(surv_cnt_o == NW'(exp_s), "R9 survivor count", longint'(surv_cnt_o), longint'(exp_s));
      chk(best_cost_o == exp_best, "R10 best cost", longint'(best_cost_o), longint'(exp_best));
      chk(cost_inv_o == exp_inv, "R11 inversion flag", longint'(cost_inv_o), longint'(exp_inv));
      chk(busy_o == 1'b0, "R9 idle at end", longint'(busy_o), 0);
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1, "R9 done held", longint'(done_o), 1);
   endtask

   initial begin
      #(5.0 * 190000);
      nfail++;
      $display("FAIL watchdog: simulation hung, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; seed_i = '0; cut_thr_i = '0; mut_thr_i = '0;
      xover_lim_i = NW'(1); epoch_len_i = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(busy_o == 1'b0, "R13 busy", longint'(busy_o), 0);
      chk(done_o == 1'b0, "R13 done", longint'(done_o), 0);
      chk(cost_req_o == 1'b0, "R13 cost request", longint'(cost_req_o), 0);
      chk(wr_valid_o == 1'b0, "R13 write valid", longint'(wr_valid_o), 0);
      chk(best_cost_o == '1, "R13 best cost", longint'(best_cost_o), longint'(16'hFFFF));
      chk(xover_cnt_o == '0 && surv_cnt_o == '0, "R13 counters", longint'(xover_cnt_o), 0);

      run_case(32'h1234_5678, 16'h2000, 16'h0C00, 400, 0, 1'b0); // R4 R5 R6 main search
      run_case(32'h0000_0000, 16'hFFFF, 16'h0400, 150, 0, 1'b0); // R1 zero seed, R6 always switch
      run_case(32'h0BAD_F00D, 16'h0000, 16'h0000, 100, 0, 1'b0); // R5 ties, R6 child = first parent
      run_case(32'h7E57_1DEA, 16'h3000, 16'h0800, 300, 37, 1'b1); // R11 epochs, R12 start ignored

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule